// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block holds the stores of an in-order-commit core between dispatch and commit. A store takes a slot in a circular buffer when it is dispatched. Its address, data and byte enables are written into that slot when it executes. When it commits, the oldest slot is written to a simple cache write port and freed. The block exposes the current allocation pointer (`tail_tag`). A store keeps this value as its slot tag. A load keeps it as a boundary: the stores older than the load are exactly those between the oldest live slot and that boundary.

A load presents its word address and boundary. It is accepted only when every older live store has executed. On acceptance the block builds the result byte by byte. Each byte comes from the youngest older executed store whose word address matches and whose byte enable covers that byte. Any byte that no such store covers comes from the cache read port. The result appears one cycle later together with a mask of the forwarded bytes.

Dispatch and load lookup use valid/ready handshakes. A transfer happens on a clock edge where both are high. `disp_ready` drops when the buffer is full or a flush is requested. `ld_ready` drops while an older store address is unknown. The response has no ready and must be taken when `rsp_valid` is high. Commit also uses valid/ready: `cmt_ready` is high only when the oldest live store has executed. Execute, flush and the cache ports are plain signals. DEPTH must be a power of two. Pointers carry two extra bits, so a load boundary stays usable while it is up to DEPTH positions away from the oldest slot.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `tail_tag` is 0, `disp_ready` is 1, `cmt_ready` is 0 and `rsp_valid` is 0.
- R2: Each accepted dispatch takes slot `tail_tag`, and `tail_tag` then advances by one (modulo 2^PW). `disp_ready` is 0 while DEPTH stores are live.
- R3: An execute writes its word address, data and byte enables into the slot named by `ex_tag`. A later forwarding lookup or a commit of that slot uses these values.
- R4: `ld_ready` is 1 only when every live store from the oldest slot up to, but not including, `ld_tag` has executed. A boundary equal to the oldest slot position needs no stores and is always ready.
- R5: For each byte lane b (bits 8b+7..8b), the load result takes the byte from the youngest older executed store whose address equals `ld_addr` and whose enable bit b is set, and sets `rsp_fwd_mask[b]`. Otherwise it takes the byte from `cache_rd_data` and clears the mask bit. Stores at or beyond `ld_tag` have no effect on the result.
- R6: `rsp_valid` is high in the cycle after an accepted load, and only then. It carries that load's data and mask.
- R7: When a commit is accepted, `wr_valid` is high in the same cycle with the oldest store's address, data and enables, and the slot is freed.
- R8: A flush drops every live store that is not committing in the same cycle. `tail_tag` then equals the oldest slot position, and `disp_ready` is 0 during the flush cycle.
- R9: A load accepted in the same cycle as a commit still forwards from the committing store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Store dispatch request |
| disp_ready | output | 1 | Slot available for dispatch |
| tail_tag | output | PW | Next slot position; store tag or load boundary |
| ex_valid | input | 1 | Store execute strobe |
| ex_tag | input | PW | Slot of the executing store |
| ex_addr | input | AW | Word address of the store |
| ex_data | input | DW | Store data |
| ex_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_ready | output | 1 | All older store addresses known |
| ld_tag | input | PW | Load boundary recorded at dispatch |
| ld_addr | input | AW | Load word address |
| cache_rd_addr | output | AW | Cache read address (combinational) |
| cache_rd_data | input | DW | Cache read data, same cycle |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | DW | Load result data |
| rsp_fwd_mask | output | DW/8 | Bytes taken from the buffer |
| cmt_valid | input | 1 | Commit the oldest store |
| cmt_ready | output | 1 | Oldest store has executed |
| wr_valid | output | 1 | Cache write strobe |
| wr_addr | output | AW | Cache write word address |
| wr_data | output | DW | Cache write data |
| wr_be | output | DW/8 | Cache write byte enables |
| flush | input | 1 | Discard all uncommitted stores |

## Verification
The critical overlap is a load lookup in the same cycle as the commit of a store that the load depends on. The buffer must still forward from the departing slot, because the cache will not hold that value until after the edge. The bench provokes this with a directed case and again in a long random mix. In that mix, dispatch, execute, commit, flush and loads with random boundaries are driven together on each cycle. Every result is judged against a reference view: the bench's memory copy, overlaid in program order with the bench's record of the older live stores as they stood before the edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_DEPTH_DEF = 8;
  localparam int unsigned SB_AW_DEF    = 16;
  localparam int unsigned SB_DW_DEF    = 32;

  function automatic int unsigned sb_ptr_bits(input int unsigned depth);
    return $clog2(depth) + 2;
  endfunction
endpackage

// File: rtl/sb_ring.sv
module sb_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          retire,
  input  logic          flush,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] count,
  output logic          full
);
  logic [PW-1:0] head_nx;

  assign head_nx = head + PW'(retire);
  assign count   = tail - head;
  assign full    = (count == PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head_nx;
      if (flush)      tail <= head_nx;
      else if (alloc) tail <= tail + 1'b1;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail == head));
  a_r7_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (head == $past(head) + 1'b1));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned PW    = 5,
  localparam int unsigned WB   = DW / 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic [PW-1:0] head,
  input  logic [PW-1:0] ld_tag,
  input  logic [AW-1:0] ld_addr,
  input  logic          ent_aval [DEPTH],
  input  logic [AW-1:0] ent_addr [DEPTH],
  input  logic [DW-1:0] ent_data [DEPTH],
  input  logic [WB-1:0] ent_be   [DEPTH],
  input  logic [DW-1:0] cache_data,
  output logic          resolved,
  output logic [DW-1:0] merged,
  output logic [WB-1:0] fwd_mask
);
  logic [PW-1:0] span;
  logic          in_range;

  assign span     = ld_tag - head;
  assign in_range = (span <= PW'(DEPTH));

  // Walk oldest to youngest so that younger matches overwrite older ones.
  always_comb begin
    logic [IW-1:0] idx;
    resolved = 1'b1;
    merged   = cache_data;
    fwd_mask = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head[IW-1:0] + IW'(k);
      if (in_range && (PW'(k) < span)) begin
        if (!ent_aval[idx]) begin
          resolved = 1'b0;
        end else if (ent_addr[idx] == ld_addr) begin
          for (int b = 0; b < WB; b++) begin
            if (ent_be[idx][b]) begin
              merged[b*8 +: 8] = ent_data[idx][b*8 +: 8];
              fwd_mask[b]      = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int unsigned DEPTH = sb_pkg::SB_DEPTH_DEF,
  parameter int unsigned AW    = sb_pkg::SB_AW_DEF,
  parameter int unsigned DW    = sb_pkg::SB_DW_DEF,
  localparam int unsigned WB   = DW / 8,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned PW   = sb_pkg::sb_ptr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  output logic          disp_ready,
  output logic [PW-1:0] tail_tag,
  input  logic          ex_valid,
  input  logic [PW-1:0] ex_tag,
  input  logic [AW-1:0] ex_addr,
  input  logic [DW-1:0] ex_data,
  input  logic [WB-1:0] ex_be,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [PW-1:0] ld_tag,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] cache_rd_addr,
  input  logic [DW-1:0] cache_rd_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [WB-1:0] rsp_fwd_mask,
  input  logic          cmt_valid,
  output logic          cmt_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [WB-1:0] wr_be,
  input  logic          flush
);
  logic          ent_aval [DEPTH];
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [WB-1:0] ent_be   [DEPTH];

  logic [PW-1:0] head, tail, count;
  logic          full, alloc, retire, ld_fire, resolved;
  logic [DW-1:0] merged;
  logic [WB-1:0] fmask;
  logic [IW-1:0] hidx;

  assign disp_ready = !full && !flush;
  assign alloc      = disp_valid && disp_ready;
  assign hidx       = head[IW-1:0];
  assign cmt_ready  = (count != '0) && ent_aval[hidx];
  assign retire     = cmt_valid && cmt_ready;
  assign tail_tag   = tail;

  sb_ring #(.DEPTH(DEPTH), .PW(PW)) u_ring (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_fwd (
    .head(head), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .ent_aval(ent_aval), .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be),
    .cache_data(cache_rd_data), .resolved(resolved), .merged(merged), .fwd_mask(fmask)
  );

  assign cache_rd_addr = ld_addr;
  assign ld_ready      = resolved;
  assign ld_fire       = ld_valid && ld_ready;

  // A freshly allocated slot starts unexecuted.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_aval[i] <= 1'b0;
        end else if (alloc && tail[IW-1:0] == IW'(i)) begin
          ent_aval[i] <= 1'b0;
        end else if (ex_valid && ex_tag[IW-1:0] == IW'(i)) begin
          ent_aval[i] <= 1'b1;
        end
        if (ex_valid && ex_tag[IW-1:0] == IW'(i)) begin
          ent_addr[i] <= ex_addr;
          ent_data[i] <= ex_data;
          ent_be[i]   <= ex_be;
        end
      end
    end
  endgenerate

  assign wr_valid = retire;
  assign wr_addr  = ent_addr[hidx];
  assign wr_data  = ent_data[hidx];
  assign wr_be    = ent_be[hidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_fwd_mask <= '0;
    end else begin
      rsp_valid <= ld_fire;
      if (ld_fire) begin
        rsp_data     <= merged;
        rsp_fwd_mask <= fmask;
      end
    end
  end

  a_r6_rsp_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ld_valid && ld_ready));
  a_r3_exec_live_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> (PW'(ex_tag - head) < count));
  a_r7_commit_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_ready) |=> (count == $past(count) - 1'b1 + PW'($past(alloc)))
                                   || $past(flush));
endmodule

// File: tb/tb_store_fwd_buffer.sv
module tb_store_fwd_buffer;
  localparam int DEPTH = 8, AW = 16, DW = 32, WB = 4, PW = 5, NS = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, ex_valid = 0, ld_valid = 0, cmt_valid = 0, flush = 0;
  logic disp_ready, ld_ready, cmt_ready, rsp_valid, wr_valid;
  logic [PW-1:0] tail_tag, ex_tag = '0, ld_tag = '0;
  logic [AW-1:0] ex_addr = '0, ld_addr = '0, cache_rd_addr, wr_addr;
  logic [DW-1:0] ex_data = '0, cache_rd_data, rsp_data, wr_data;
  logic [WB-1:0] ex_be = '0, rsp_fwd_mask, wr_be;

  always #4 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  logic [31:0] cache_mem [8];
  logic [31:0] ref_mem [8];
  assign cache_rd_data = cache_mem[cache_rd_addr[2:0]];
  always @(posedge clk) if (wr_valid)
    for (int b = 0; b < WB; b++) if (wr_be[b]) cache_mem[wr_addr[2:0]][b*8 +: 8] <= wr_data[b*8 +: 8];

  int checks = 0, errors = 0, n_cmt = 0, n_disp = 0;
  logic [AW-1:0] m_addr [NS];
  logic [DW-1:0] m_data [NS];
  logic [WB-1:0] m_be   [NS];
  bit            m_exec [NS];
  logic [35:0]   sb_q [$];
  bit            done = 0;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mdl_ready(input int bnd);
    for (int s = n_cmt; s < bnd; s++) if (!m_exec[s]) return 0;
    return 1;
  endfunction

  function automatic logic [35:0] mdl_load(input logic [AW-1:0] a, input int bnd);
    logic [31:0] d = ref_mem[a[2:0]];
    logic [3:0]  m = '0;
    for (int s = n_cmt; s < bnd; s++)
      if (m_addr[s] == a)
        for (int b = 0; b < WB; b++) if (m_be[s][b]) begin
          d[b*8 +: 8] = m_data[s][b*8 +: 8];
          m[b] = 1'b1;
        end
    return {m, d};
  endfunction

  // Monitor: pops expected results as the design produces them (R5, R6).
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (sb_q.size() == 0) chk("R6 unexpected response", {rsp_fwd_mask, rsp_data}, 36'h0);
    else chk("R5 R6 load result", {rsp_fwd_mask, rsp_data}, sb_q.pop_front());
  end

  task automatic cyc(input bit dsp, input bit exv, input int exs, input logic [AW-1:0] exa,
                     input logic [DW-1:0] exd, input logic [WB-1:0] exb,
                     input bit ldv, input int ldb, input logic [AW-1:0] lda,
                     input bit cmv, input bit fl);
    bit d_ok, c_ok, l_ok;
    @(negedge clk);
    disp_valid = dsp; ex_valid = exv; ex_tag = PW'(exs); ex_addr = exa; ex_data = exd; ex_be = exb;
    ld_valid = ldv; ld_tag = PW'(ldb); ld_addr = lda; cmt_valid = cmv; flush = fl;
    #1;
    chk("R2 tail_tag", {31'd0, tail_tag}, {31'd0, PW'(n_disp)});
    d_ok = ((n_disp - n_cmt) < DEPTH) && !fl;
    chk("R2 R8 disp_ready", {35'd0, disp_ready}, {35'd0, d_ok});
    c_ok = (n_cmt < n_disp) && m_exec[n_cmt];
    chk("R7 cmt_ready", {35'd0, cmt_ready}, {35'd0, c_ok});
    if (cmv && c_ok)
      chk("R7 R3 cache write", {wr_be, wr_data}, {m_be[n_cmt], m_data[n_cmt]});
    if (ldv) begin
      l_ok = mdl_ready(ldb);
      chk("R4 ld_ready", {35'd0, ld_ready}, {35'd0, l_ok});
      if (l_ok) sb_q.push_back(mdl_load(lda, ldb)); // R9: pre-commit view
    end
    @(posedge clk);
    if (exv) begin
      m_addr[exs] = exa; m_data[exs] = exd; m_be[exs] = exb; m_exec[exs] = 1;
    end
    if (cmv && c_ok) begin
      for (int b = 0; b < WB; b++)
        if (m_be[n_cmt][b]) ref_mem[m_addr[n_cmt][2:0]][b*8 +: 8] = m_data[n_cmt][b*8 +: 8];
      n_cmt++;
    end
    if (fl) n_disp = n_cmt;
    else if (dsp && d_ok) begin
      m_exec[n_disp] = 0; m_addr[n_disp] = '1; n_disp++;
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin cache_mem[i] = 32'hC0DE0000 + i; ref_mem[i] = 32'hC0DE0000 + i; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset tail_tag", {31'd0, tail_tag}, 36'd0);
    chk("R1 reset disp_ready", {35'd0, disp_ready}, 36'd1);
    chk("R1 reset cmt_ready", {35'd0, cmt_ready}, 36'd0);
    chk("R1 reset rsp_valid", {35'd0, rsp_valid}, 36'd0);
    // Three stores in order, then gate loads on older addresses (R2, R4).
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 16'd5, 0, 0);
    cyc(0, 1, 1, 16'd5, 32'h11223344, 4'b0011, 1, 3, 16'd5, 0, 0);
    cyc(0, 1, 2, 16'd6, 32'h55667788, 4'b1111, 1, 3, 16'd5, 0, 0);
    cyc(0, 1, 0, 16'd5, 32'hAAAAAAAA, 4'b1111, 0, 0, 0, 0, 0);
    // R5: youngest match per byte, boundaries that exclude younger stores.
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 16'd5, 0, 0);   // AAAA3344 mask F
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 16'd5, 0, 0);   // AAAAAAAA
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 16'd5, 0, 0);   // cache, mask 0
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 16'd7, 0, 0);   // cache, no match
    // R9: commit of s0 and dependent load in the same cycle.
    cyc(0, 0, 0, 0, 0, 0, 1, 3, 16'd5, 1, 0);
    // R2: fill to DEPTH, then one more dispatch must stall.
    repeat (7) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: flush drops live stores, dispatch blocked in that cycle.
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, n_disp, 16'd5, 0, 0);
    idle();
    // Random interleaving.
    for (int it = 0; it < 4000; it++) begin
      bit dsp, exv, ldv, cmv, fl; int exs, ldb, live;
      live = n_disp - n_cmt;
      dsp = $urandom % 2;
      exs = (live > 0) ? n_cmt + int'($urandom % live) : 0;
      exv = (live > 0) && !m_exec[exs] && ($urandom % 3 != 0);
      fl  = !exv && ($urandom % 48 == 0);
      ldv = $urandom % 2;
      ldb = n_cmt + int'($urandom % (live + 1));
      cmv = $urandom % 3 == 0;
      cyc(dsp, exv, exs, AW'($urandom % 8), $urandom, WB'($urandom), ldv, ldb,
          AW'($urandom % 8), cmv, fl);
    end
    idle(); idle();
    chk("R6 all loads answered", 36'(sb_q.size()), 36'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule